// File: doc/BRIEF.md
# Speculative Read Address Tracker

This block keeps a small fully associative address store for each speculative thread that is in flight. A thread is given a buffer ID when it is spawned. From then on, every speculative read it makes on any processor port records the read address in that buffer. Each processor port can insert one address per cycle, and several ports may insert in the same cycle, into the same buffer or into different ones.

Writes from non-speculative code on each local port, and invalidates arriving from the external bus, are compared in parallel against every recorded entry of every buffer. Any match marks the entry as killed in all buffers at once. A killed entry stays in place until the thread's buffer is cleared. Each buffer drives one violation flag to the commit logic. The flag is an OR reduction over the buffer's killed bits and its sticky overflow bit. The commit logic reads the flag when the thread is ready to commit, and then clears the buffer on commit or on retry.

Top module: `spec_read_tracker`

## Requirements
- R1: After reset every bit of `violation` and `overflow` is 0.
- R2: A valid insert on port p stores `insAddr[p]` in buffer `insBuf[p]`. A later invalidate of that address from a local port sets `violation` of that buffer on the clock edge that samples the invalidate.
- R3: An invalidate on the external bus input (`extInvValid`, `extInvAddr`) has the same effect as one from a local port.
- R4: One invalidate sets the violation flag of every buffer that holds the address, in the same cycle. Buffers that do not hold it are unchanged.
- R5: Inserts on different ports in the same cycle are all recorded. This holds whether they target different buffers or the same buffer.
- R6: A violation flag stays set until its buffer is cleared, even when no further traffic arrives.
- R7: An insert of a new address into a buffer whose DEPTH entries are all in use sets that buffer's `overflow` and `violation` on the next edge. Both stay set until the buffer is cleared.
- R8: Inserting an address the buffer already holds, or the same address on two ports in one cycle, takes no extra entry.
- R9: If an address is inserted in the same cycle that an invalidate of the same address arrives, the new entry is recorded as killed.
- R10: A clear (`clrValid` with ID `clrBuf`) empties that buffer and drops its violation and overflow flags on the next edge. It takes priority over inserts to the same buffer in that cycle, which are discarded. Other buffers are unaffected.
- R11: An invalidate of an address that no buffer currently holds changes no flag.
- R12: When several ports insert distinct new addresses into one buffer in one cycle, each takes its own free entry, lowest port first. Any that find no free entry set `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | NUM_INS | Per-port speculative read insert strobe |
| insBuf | input | NUM_INS*ID_W | Per-port target buffer ID, port p at bits [p*ID_W +: ID_W] |
| insAddr | input | NUM_INS*ADDR_W | Per-port read address, port p at bits [p*ADDR_W +: ADDR_W] |
| locInvValid | input | NUM_INS | Per-port local write invalidate strobe |
| locInvAddr | input | NUM_INS*ADDR_W | Per-port invalidate address |
| extInvValid | input | 1 | External bus invalidate strobe |
| extInvAddr | input | ADDR_W | External bus invalidate address |
| clrValid | input | 1 | Buffer clear strobe (commit or retry) |
| clrBuf | input | ID_W | ID of the buffer to clear |
| violation | output | NUM_BUFS | Per-buffer flag: a recorded read was invalidated, or the buffer overflowed |
| overflow | output | NUM_BUFS | Per-buffer sticky overflow flag |

## Verification
All state sits behind registers, so a wrong internal state shows at the ports on the edge that follows the stimulus. Three examples:
- A kill bit that is lost or set on the wrong slot shows as a missing or stray violation bit one cycle after the invalidate.
- A slot that is wrongly treated as free or as taken moves the cycle in which overflow rises. The bench checks this by filling a buffer to exactly DEPTH entries, with duplicates mixed in, and then adding one more address.
- A clear that leaks into a neighbouring buffer, or a same-cycle insert that is not discarded, shows in the flags of the next cycle or after a later invalidate.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;
  // Width of the source-port field in a slot command; limits NUM_INS to 16.
  localparam int SRC_W = 4;

  // Strobes sent from the allocation control to one storage slot.
  typedef struct packed {
    logic             load;     // write a new address into this slot
    logic             killNew;  // the address being loaded is invalidated this cycle
    logic             kill;     // the stored address matched an invalidate
    logic [SRC_W-1:0] src;      // insert port that supplies the address
  } slotCmd_t;
endpackage

// File: rtl/srt_store.sv
`timescale 1ns/1ps
module srt_store
  import srt_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 16,
  parameter int NUM_INS  = 4,
  parameter int NUM_INV  = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_INS*ADDR_W-1:0]      insAddr,
  input  logic [NUM_INV-1:0]             invValid,
  input  logic [NUM_INV*ADDR_W-1:0]      invAddr,
  input  slotCmd_t [NUM_BUFS*DEPTH-1:0]  slotCmd,
  input  logic [NUM_BUFS-1:0]            clrMask,
  input  logic [NUM_BUFS-1:0]            ovfSet,
  output logic [NUM_BUFS*DEPTH-1:0]      slotValid,
  output logic [NUM_BUFS*DEPTH-1:0]      staleHit,
  output logic [NUM_BUFS*NUM_INS-1:0]    dupHit,
  output logic [NUM_INS-1:0]             raceHit,
  output logic [NUM_INS*NUM_INS-1:0]     portEq,
  output logic [NUM_BUFS-1:0]            violation,
  output logic [NUM_BUFS-1:0]            overflow
);
  localparam int SLOTS  = NUM_BUFS * DEPTH;
  localparam int PORT_W = (NUM_INS > 1) ? $clog2(NUM_INS) : 1;

  logic [ADDR_W-1:0] portAddr [NUM_INS];
  logic [ADDR_W-1:0] killAddr [NUM_INV];
  logic [ADDR_W-1:0] addrQ    [SLOTS];
  logic [SLOTS-1:0]  validQ, killedQ;
  logic [NUM_BUFS-1:0] ovfQ;

  for (genvar p = 0; p < NUM_INS; p++) begin : g_portUnpack
    assign portAddr[p] = insAddr[p*ADDR_W +: ADDR_W];
  end
  for (genvar k = 0; k < NUM_INV; k++) begin : g_invUnpack
    assign killAddr[k] = invAddr[k*ADDR_W +: ADDR_W];
  end

  // Address storage needs no reset: validQ qualifies every use.
  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (slotCmd[i].load) addrQ[i] <= portAddr[slotCmd[i].src[PORT_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      killedQ <= '0;
      ovfQ    <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (clrMask[i / DEPTH]) begin
          validQ[i]  <= 1'b0;
          killedQ[i] <= 1'b0;
        end else if (slotCmd[i].load) begin
          validQ[i]  <= 1'b1;
          killedQ[i] <= slotCmd[i].killNew;
        end else if (slotCmd[i].kill) begin
          killedQ[i] <= 1'b1;
        end
      end
      for (int b = 0; b < NUM_BUFS; b++) begin
        if (clrMask[b])     ovfQ[b] <= 1'b0;
        else if (ovfSet[b]) ovfQ[b] <= 1'b1;
      end
    end
  end

  // Every stored entry against every invalidate address.
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      staleHit[i] = 1'b0;
      for (int k = 0; k < NUM_INV; k++) begin
        if (validQ[i] && invValid[k] && (killAddr[k] == addrQ[i])) staleHit[i] = 1'b1;
      end
    end
  end

  // Insert addresses against stored entries, invalidates and each other.
  always_comb begin
    for (int b = 0; b < NUM_BUFS; b++) begin
      for (int p = 0; p < NUM_INS; p++) begin
        dupHit[b*NUM_INS+p] = 1'b0;
        for (int e = 0; e < DEPTH; e++) begin
          if (validQ[b*DEPTH+e] && (addrQ[b*DEPTH+e] == portAddr[p]))
            dupHit[b*NUM_INS+p] = 1'b1;
        end
      end
    end
    for (int p = 0; p < NUM_INS; p++) begin
      raceHit[p] = 1'b0;
      for (int k = 0; k < NUM_INV; k++) begin
        if (invValid[k] && (killAddr[k] == portAddr[p])) raceHit[p] = 1'b1;
      end
      for (int q = 0; q < NUM_INS; q++) begin
        portEq[p*NUM_INS+q] = (q < p) && (portAddr[q] == portAddr[p]);
      end
    end
  end

  // Commit status: one OR tree per buffer.
  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_flag
    assign violation[b] = (|killedQ[b*DEPTH +: DEPTH]) | ovfQ[b];
  end
  assign overflow  = ovfQ;
  assign slotValid = validQ;
endmodule

// File: rtl/srt_ctrl.sv
`timescale 1ns/1ps
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int DEPTH    = 4,
  parameter int NUM_INS  = 4,
  parameter int ID_W     = 2
) (
  input  logic [NUM_INS-1:0]             insValid,
  input  logic [NUM_INS*ID_W-1:0]        insBuf,
  input  logic                           clrValid,
  input  logic [ID_W-1:0]                clrBuf,
  input  logic [NUM_BUFS*DEPTH-1:0]      slotValid,
  input  logic [NUM_BUFS*DEPTH-1:0]      staleHit,
  input  logic [NUM_BUFS*NUM_INS-1:0]    dupHit,
  input  logic [NUM_INS-1:0]             raceHit,
  input  logic [NUM_INS*NUM_INS-1:0]     portEq,
  output slotCmd_t [NUM_BUFS*DEPTH-1:0]  slotCmd,
  output logic [NUM_BUFS-1:0]            clrMask,
  output logic [NUM_BUFS-1:0]            ovfSet
);
  // Ports ordered by index: each new address takes the lowest free slot.
  always_comb begin : alloc
    logic [DEPTH-1:0] freeM;
    logic             taken;
    logic             seen;
    slotCmd = '0;
    clrMask = '0;
    ovfSet  = '0;
    freeM   = '0;
    taken   = 1'b0;
    seen    = 1'b0;
    for (int b = 0; b < NUM_BUFS; b++) begin
      clrMask[b] = clrValid && (clrBuf == ID_W'(b));
      for (int e = 0; e < DEPTH; e++) slotCmd[b*DEPTH+e].kill = staleHit[b*DEPTH+e];
      freeM = ~slotValid[b*DEPTH +: DEPTH];
      if (!clrMask[b]) begin
        for (int p = 0; p < NUM_INS; p++) begin
          if (insValid[p] && (insBuf[p*ID_W +: ID_W] == ID_W'(b)) && !dupHit[b*NUM_INS+p]) begin
            seen = 1'b0;
            for (int q = 0; q < NUM_INS; q++) begin
              if (insValid[q] && (insBuf[q*ID_W +: ID_W] == ID_W'(b)) && portEq[p*NUM_INS+q])
                seen = 1'b1;
            end
            if (!seen) begin
              taken = 1'b0;
              for (int e = 0; e < DEPTH; e++) begin
                if (!taken && freeM[e]) begin
                  slotCmd[b*DEPTH+e].load    = 1'b1;
                  slotCmd[b*DEPTH+e].killNew = raceHit[p];
                  slotCmd[b*DEPTH+e].src     = SRC_W'(p);
                  freeM[e] = 1'b0;
                  taken    = 1'b1;
                end
              end
              if (!taken) ovfSet[b] = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spec_read_tracker.sv
`timescale 1ns/1ps
module spec_read_tracker
  import srt_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 16,
  parameter int NUM_INS  = 4,
  localparam int ID_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_INS-1:0]        insValid,
  input  logic [NUM_INS*ID_W-1:0]   insBuf,
  input  logic [NUM_INS*ADDR_W-1:0] insAddr,
  input  logic [NUM_INS-1:0]        locInvValid,
  input  logic [NUM_INS*ADDR_W-1:0] locInvAddr,
  input  logic                      extInvValid,
  input  logic [ADDR_W-1:0]         extInvAddr,
  input  logic                      clrValid,
  input  logic [ID_W-1:0]           clrBuf,
  output logic [NUM_BUFS-1:0]       violation,
  output logic [NUM_BUFS-1:0]       overflow
);
  localparam int NUM_INV = NUM_INS + 1;   // local ports, then the external bus on top
  localparam int SLOTS   = NUM_BUFS * DEPTH;

  logic [NUM_INV-1:0]          invValid;
  logic [NUM_INV*ADDR_W-1:0]   invAddr;
  slotCmd_t [SLOTS-1:0]        slotCmd;
  logic [NUM_BUFS-1:0]         clrMask, ovfSet;
  logic [SLOTS-1:0]            slotValid, staleHit;
  logic [NUM_BUFS*NUM_INS-1:0] dupHit;
  logic [NUM_INS-1:0]          raceHit;
  logic [NUM_INS*NUM_INS-1:0]  portEq;

  assign invValid = {extInvValid, locInvValid};
  assign invAddr  = {extInvAddr, locInvAddr};

  srt_ctrl #(
    .NUM_BUFS(NUM_BUFS), .DEPTH(DEPTH), .NUM_INS(NUM_INS), .ID_W(ID_W)
  ) u_ctrl (
    .insValid (insValid),
    .insBuf   (insBuf),
    .clrValid (clrValid),
    .clrBuf   (clrBuf),
    .slotValid(slotValid),
    .staleHit (staleHit),
    .dupHit   (dupHit),
    .raceHit  (raceHit),
    .portEq   (portEq),
    .slotCmd  (slotCmd),
    .clrMask  (clrMask),
    .ovfSet   (ovfSet)
  );

  srt_store #(
    .NUM_BUFS(NUM_BUFS), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .NUM_INS(NUM_INS), .NUM_INV(NUM_INV)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .insAddr  (insAddr),
    .invValid (invValid),
    .invAddr  (invAddr),
    .slotCmd  (slotCmd),
    .clrMask  (clrMask),
    .ovfSet   (ovfSet),
    .slotValid(slotValid),
    .staleHit (staleHit),
    .dupHit   (dupHit),
    .raceHit  (raceHit),
    .portEq   (portEq),
    .violation(violation),
    .overflow (overflow)
  );
endmodule

// File: rtl/spec_read_tracker_chk.sv
`timescale 1ns/1ps
module spec_read_tracker_chk #(
  parameter int NUM_BUFS = 4,
  parameter int NUM_INS  = 4,
  parameter int ID_W     = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_INS-1:0]      insValid,
  input logic [NUM_INS*ID_W-1:0] insBuf,
  input logic [NUM_INS-1:0]      locInvValid,
  input logic                    extInvValid,
  input logic                    clrValid,
  input logic [ID_W-1:0]         clrBuf,
  input logic [NUM_BUFS-1:0]     violation,
  input logic [NUM_BUFS-1:0]     overflow
);
  logic [NUM_BUFS-1:0] insToB, clrHit;
  logic                anyInv;

  assign anyInv = (|locInvValid) | extInvValid;

  always_comb begin
    for (int b = 0; b < NUM_BUFS; b++) begin
      insToB[b] = 1'b0;
      for (int p = 0; p < NUM_INS; p++) begin
        if (insValid[p] && (insBuf[p*ID_W +: ID_W] == ID_W'(b))) insToB[b] = 1'b1;
      end
      clrHit[b] = clrValid && (clrBuf == ID_W'(b));
    end
  end

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_chk
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
      clrHit[b] |=> (!violation[b] && !overflow[b]));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
      (violation[b] && !clrHit[b]) |=> violation[b]);

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(overflow[b]) |-> $past(insToB[b]));

    assert_viol_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(violation[b]) |-> $past(insToB[b] || anyInv));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
      (!insToB[b] && !anyInv && !clrHit[b]) |=> $stable(violation[b]));
  end
endmodule

bind spec_read_tracker spec_read_tracker_chk #(
  .NUM_BUFS(NUM_BUFS), .NUM_INS(NUM_INS), .ID_W(ID_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .insValid   (insValid),
  .insBuf     (insBuf),
  .locInvValid(locInvValid),
  .extInvValid(extInvValid),
  .clrValid   (clrValid),
  .clrBuf     (clrBuf),
  .violation  (violation),
  .overflow   (overflow)
);

// File: tb/spec_read_tracker_test.sv
`timescale 1ns/1ps
module spec_read_tracker_test;
  localparam int NB = 4;
  localparam int NI = 4;
  localparam int AW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NI-1:0] insValid;
  logic [NI*IW-1:0] insBuf;
  logic [NI*AW-1:0] insAddr;
  logic [NI-1:0] locInvValid;
  logic [NI*AW-1:0] locInvAddr;
  logic          extInvValid;
  logic [AW-1:0] extInvAddr;
  logic          clrValid;
  logic [IW-1:0] clrBuf;
  logic [NB-1:0] violation, overflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  spec_read_tracker #(.NUM_BUFS(NB), .DEPTH(4), .ADDR_W(AW), .NUM_INS(NI)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One row = one cycle: one insert, one invalidate (src 4 = external bus), one clear.
  typedef struct packed {
    logic        insEn;
    logic [1:0]  insPort;
    logic [1:0]  insId;
    logic [15:0] insA;
    logic        invEn;
    logic [2:0]  invSrc;
    logic [15:0] invA;
    logic        clrEn;
    logic [1:0]  clrId;
    logic [3:0]  expV;
    logic [3:0]  expO;
    logic [7:0]  reqN;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{1'b1,2'd0,2'd0,16'h0100, 1'b0,3'd0,16'h0000, 1'b0,2'd0, 4'b0000,4'b0000,8'd2},  // R2 record
    '{1'b1,2'd1,2'd1,16'h0100, 1'b0,3'd0,16'h0000, 1'b0,2'd0, 4'b0000,4'b0000,8'd2},  // R2 same addr, buf1
    '{1'b1,2'd2,2'd2,16'h0200, 1'b0,3'd0,16'h0000, 1'b0,2'd0, 4'b0000,4'b0000,8'd2},  // R2
    '{1'b0,2'd0,2'd0,16'h0000, 1'b1,3'd3,16'h0300, 1'b0,2'd0, 4'b0000,4'b0000,8'd11}, // R11 miss
    '{1'b0,2'd0,2'd0,16'h0000, 1'b1,3'd0,16'h0100, 1'b0,2'd0, 4'b0011,4'b0000,8'd4},  // R4 both bufs
    '{1'b0,2'd0,2'd0,16'h0000, 1'b0,3'd0,16'h0000, 1'b0,2'd0, 4'b0011,4'b0000,8'd6},  // R6 sticky
    '{1'b0,2'd0,2'd0,16'h0000, 1'b1,3'd4,16'h0200, 1'b0,2'd0, 4'b0111,4'b0000,8'd3},  // R3 external
    '{1'b0,2'd0,2'd0,16'h0000, 1'b0,3'd0,16'h0000, 1'b1,2'd0, 4'b0110,4'b0000,8'd10}, // R10 clear 0
    '{1'b1,2'd0,2'd0,16'h0100, 1'b0,3'd0,16'h0000, 1'b0,2'd0, 4'b0110,4'b0000,8'd10}, // R10 fresh entry
    '{1'b1,2'd3,2'd3,16'h0400, 1'b1,3'd4,16'h0400, 1'b0,2'd0, 4'b1110,4'b0000,8'd9},  // R9 race
    '{1'b0,2'd0,2'd0,16'h0000, 1'b0,3'd0,16'h0000, 1'b1,2'd1, 4'b1100,4'b0000,8'd10}, // R10
    '{1'b0,2'd0,2'd0,16'h0000, 1'b0,3'd0,16'h0000, 1'b1,2'd2, 4'b1000,4'b0000,8'd10}, // R10
    '{1'b0,2'd0,2'd0,16'h0000, 1'b0,3'd0,16'h0000, 1'b1,2'd3, 4'b0000,4'b0000,8'd10}, // R10
    '{1'b0,2'd0,2'd0,16'h0000, 1'b1,3'd4,16'h0400, 1'b0,2'd0, 4'b0000,4'b0000,8'd11}  // R11 after clear
  };

  task automatic idle();
    insValid = '0; insBuf = '0; insAddr = '0;
    locInvValid = '0; locInvAddr = '0;
    extInvValid = 1'b0; extInvAddr = '0;
    clrValid = 1'b0; clrBuf = '0;
  endtask

  task automatic ins(input int p, input int id, input logic [AW-1:0] a);
    insValid[p] = 1'b1;
    insBuf[p*IW +: IW] = IW'(id);
    insAddr[p*AW +: AW] = a;
  endtask

  task automatic invLoc(input int p, input logic [AW-1:0] a);
    locInvValid[p] = 1'b1;
    locInvAddr[p*AW +: AW] = a;
  endtask

  task automatic invExt(input logic [AW-1:0] a);
    extInvValid = 1'b1;
    extInvAddr = a;
  endtask

  task automatic clr(input int id);
    clrValid = 1'b1;
    clrBuf = IW'(id);
  endtask

  // Inputs are set 1 ns after an edge; flags are sampled 1 ns after the next one.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [NB-1:0] expV, input logic [NB-1:0] expO);
    checks++;
    if (violation !== expV || overflow !== expO) begin
      errors++;
      $display("FAIL %s: violation %b overflow %b, expected violation %b overflow %b",
               req, violation, overflow, expV, expO);
    end
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    doReset();
    chk("R1", 4'b0000, 4'b0000);

    for (int r = 0; r < 14; r++) begin
      idle();
      if (VECS[r].insEn) ins(int'(VECS[r].insPort), int'(VECS[r].insId), VECS[r].insA);
      if (VECS[r].invEn) begin
        if (VECS[r].invSrc == 3'd4) invExt(VECS[r].invA);
        else invLoc(int'(VECS[r].invSrc), VECS[r].invA);
      end
      if (VECS[r].clrEn) clr(int'(VECS[r].clrId));
      tick();
      chk($sformatf("R%0d row %0d", VECS[r].reqN, r), VECS[r].expV, VECS[r].expO);
    end

    // R5: four ports, four buffers, one cycle.
    doReset();
    ins(0, 0, 16'h0010); ins(1, 1, 16'h0011); ins(2, 2, 16'h0012); ins(3, 3, 16'h0013);
    tick();
    chk("R5 parallel insert", 4'b0000, 4'b0000);
    idle(); invLoc(2, 16'h0012); tick();
    chk("R5 port2 entry", 4'b0100, 4'b0000);
    idle(); invExt(16'h0013); invLoc(0, 16'h0010); tick();
    chk("R5 two invalidates", 4'b1101, 4'b0000);
    idle(); invLoc(1, 16'h0011); tick();
    chk("R5 port1 entry", 4'b1111, 4'b0000);

    // R12 / R7: four ports fill one buffer in one cycle, a fifth address overflows.
    doReset();
    ins(0, 0, 16'h0020); ins(1, 0, 16'h0021); ins(2, 0, 16'h0022); ins(3, 0, 16'h0023);
    tick();
    chk("R12 fill in one cycle", 4'b0000, 4'b0000);
    idle(); ins(0, 0, 16'h0024); tick();
    chk("R7 overflow", 4'b0001, 4'b0001);
    idle(); tick();
    chk("R7 overflow sticky", 4'b0001, 4'b0001);

    // R8: repeats and same-cycle duplicates take no extra entry.
    doReset();
    for (int n = 0; n < 6; n++) begin
      idle(); ins(0, 1, 16'h0030); tick();
    end
    chk("R8 repeated insert", 4'b0000, 4'b0000);
    idle(); ins(0, 1, 16'h0031); ins(1, 1, 16'h0031); ins(2, 1, 16'h0031); ins(3, 1, 16'h0031);
    tick();
    chk("R8 same-cycle duplicate", 4'b0000, 4'b0000);
    idle(); ins(0, 1, 16'h0032); ins(1, 1, 16'h0033); tick();
    chk("R8 exactly full", 4'b0000, 4'b0000);
    idle(); ins(2, 1, 16'h0030); tick();
    chk("R8 duplicate when full", 4'b0000, 4'b0000);
    idle(); ins(0, 1, 16'h0034); tick();
    chk("R7 fifth distinct", 4'b0010, 4'b0010);

    // R12: more new addresses than free slots in one cycle.
    doReset();
    ins(0, 2, 16'h0040); ins(1, 2, 16'h0041); tick();
    idle();
    ins(0, 2, 16'h0042); ins(1, 2, 16'h0043); ins(2, 2, 16'h0044); ins(3, 2, 16'h0045);
    tick();
    chk("R12 oversubscribed", 4'b0100, 4'b0100);
    idle(); ins(3, 3, 16'h0060); tick();
    idle(); invExt(16'h0060); tick();
    chk("R4 neighbour violated", 4'b1100, 4'b0100);

    // R10: clear drops overflow, spares other buffers, and wins over a same-cycle insert.
    idle(); clr(2); tick();
    chk("R10 clear overflowed", 4'b1000, 4'b0000);
    idle(); clr(0); ins(0, 0, 16'h0050); tick();
    idle(); invLoc(0, 16'h0050); tick();
    chk("R10 insert dropped", 4'b1000, 4'b0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule